// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 2^17 bytes. The RAM has two chip selects of opposite polarity (one active low, one active high), an active-low output enable and an active-low write strobe. The host hands over one access at a time on a valid/ready request channel. The controller then drives the RAM pins through a fixed strobe sequence, timed in clock cycles, and reports completion with a one-cycle response pulse. For a read, that pulse carries the captured byte.

The request channel follows valid/ready rules. The host raises `req_valid` with stable `req_write`, `req_addr` and `req_wdata` and keeps all of them unchanged until it sees a cycle with `req_ready` high. A transfer happens on the clock edge where both are high. `req_ready` is high only while the sequencer is idle, and that is the only back-pressure. The response channel has no back-pressure: `rsp_valid` is a one-cycle pulse and the host must take it.

The shared RAM data bus is modelled as three signals: `mem_dq_out`, `mem_dq_oe` and `mem_dq_in`. All strobe timings come from picosecond parameters, converted to cycle counts using the clock period. The RAM stays deselected whenever no access is in progress.

Top module: `sram_ctl_top`

## Requirements
- R1: During reset and while idle, the pins are in the deselected state: `mem_ce1_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0. In the same state `req_ready`=1 and `rsp_valid`=0. An asynchronous reset in the middle of an access returns the pins to this state at once.
- R2: A request is taken on the edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the sequencer is idle again. A request held pending during a busy period is taken on the first edge after `req_ready` returns to 1.
- R3: A read drives `mem_ce1_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1 for RD+1 consecutive cycles, starting in the cycle after acceptance. RD is the access time divided by the clock period, rounded up. `mem_dq_oe` stays 0 throughout.
- R4: The byte on `mem_dq_in` in the last cycle of the read window appears on `rsp_rdata` together with `rsp_valid`, RD+1 cycles after the first cycle of the window.
- R5: A write keeps both chip selects active and `mem_oe_n`=1 for SU+PW+HD cycles. During those cycles `mem_we_n` is 1 for the first SU cycles, 0 for the next PW cycles and 1 for the last HD cycles. SU, PW and HD are the setup, pulse and hold times in cycles, each at least 1.
- R6: During the whole write window `mem_dq_oe`=1 and `mem_dq_out` equals the accepted `req_wdata`. This includes at least one cycle after `mem_we_n` rises.
- R7: `mem_addr` equals the accepted address and does not change while a chip select is active. It changes only while the RAM is deselected.
- R8: Every access produces exactly one `rsp_valid` pulse, one cycle long. For a write, the pulse comes in the first deselected cycle after the hold phase.
- R9: `mem_dq_oe` and an active `mem_oe_n` are never high together. `mem_dq_oe` rises only after `mem_oe_n` has been 1 for at least one cycle. At least one cycle separates `mem_dq_oe` falling from `mem_oe_n` falling.
- R10: After every access, the RAM stays deselected with `mem_we_n`=1 for at least REC cycles (at least 1) before the next access. `req_ready` returns to 1 REC cycles after the response pulse.
- R11: `rsp_rdata` is 0 after reset and changes only when a read completes. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host has an access pending |
| req_ready | output | 1 | Controller idle, will take the request on this edge |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 17 | Byte address of the access |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last completed read |
| mem_addr | output | 17 | RAM address lines |
| mem_ce1_n | output | 1 | RAM chip select, active low |
| mem_ce2 | output | 1 | RAM chip select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | 8 | Data the controller drives onto the shared bus |
| mem_dq_oe | output | 1 | Controller drives the shared bus |
| mem_dq_in | input | 8 | Data seen on the shared bus |

## Verification
The bench targets a write followed at once by a read that was held pending. A design that dropped the turnaround cycle would lower the output enable while still driving the bus, and a design that ignored the busy period would take the read early and move the address inside an open write window. Per-cycle strobe checks catch a write pulse that is too short, a read sampled before the access time has elapsed, and a write strobe that rises at the same moment as the chip selects instead of before them. Reads made after writes return the right bytes only if data was held through the strobe edge. A reset applied in the middle of the write pulse must deselect the pins at once. Checks on the read data across writes catch a response register that is overwritten by write completions.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_CAP,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RECOVER
  } seq_state_e;

  // Cycles needed to cover a time in ps, never fewer than min_cyc.
  function automatic int unsigned cyc_ceil(input int unsigned t_ps,
                                           input int unsigned clk_ps,
                                           input int unsigned min_cyc);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < min_cyc) ? min_cyc : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e nxt_state,
  output logic       ce1_n,
  output logic       ce2,
  output logic       oe_n,
  output logic       we_n
);
  logic sel_nxt, rd_nxt, wr_pulse_nxt;

  always_comb begin
    rd_nxt       = (nxt_state == ST_RD_WAIT) || (nxt_state == ST_RD_CAP);
    wr_pulse_nxt = (nxt_state == ST_WR_PULSE);
    sel_nxt      = rd_nxt || wr_pulse_nxt ||
                   (nxt_state == ST_WR_SETUP) || (nxt_state == ST_WR_HOLD);
  end

  // Strobes come straight from flops so the pins never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce1_n <= 1'b1;
      ce2   <= 1'b0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
    end else begin
      ce1_n <= !sel_nxt;
      ce2   <= sel_nxt;
      oe_n  <= !rd_nxt;
      we_n  <= !wr_pulse_nxt;
    end
  end
endmodule

// File: rtl/sram_bus_turn.sv
module sram_bus_turn #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want_drive,
  input  logic              oe_n_now,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              drive_en
);
  // Driving starts only if the RAM outputs are already disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_en <= 1'b0;
      dout     <= '0;
    end else begin
      drive_en <= want_drive && oe_n_now;
      if (load) dout <= din;
    end
  end
endmodule

// File: rtl/sram_ctl_top.sv
module sram_ctl_top
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W          = 17,
  parameter int unsigned DATA_W          = 8,
  parameter int unsigned CLK_PERIOD_PS   = 4000,
  parameter int unsigned T_ACCESS_PS     = 55000,
  parameter int unsigned T_ADDR_SETUP_PS = 0,
  parameter int unsigned T_WE_PULSE_PS   = 45000,
  parameter int unsigned T_DATA_HOLD_PS  = 0,
  parameter int unsigned RECOVER_CYCLES  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned RD_CYC  = cyc_ceil(T_ACCESS_PS, CLK_PERIOD_PS, 1);
  localparam int unsigned SU_CYC  = cyc_ceil(T_ADDR_SETUP_PS, CLK_PERIOD_PS, 1);
  localparam int unsigned PW_CYC  = cyc_ceil(T_WE_PULSE_PS, CLK_PERIOD_PS, 1);
  localparam int unsigned HD_CYC  = cyc_ceil(T_DATA_HOLD_PS, CLK_PERIOD_PS, 1);
  localparam int unsigned REC_CYC = (RECOVER_CYCLES < 1) ? 1 : RECOVER_CYCLES;
  localparam int unsigned CNT_W   =
    $clog2(RD_CYC + SU_CYC + PW_CYC + HD_CYC + REC_CYC + 1);

  seq_state_e        state_q, nxt_state;
  logic              tmr_load, tmr_expired;
  logic [CNT_W-1:0]  tmr_val;
  logic              accept, want_drive;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt_state = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          nxt_state = ST_WR_SETUP;
          tmr_val   = CNT_W'(SU_CYC - 1);
        end else begin
          nxt_state = ST_RD_WAIT;
          tmr_val   = CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD_WAIT: if (tmr_expired) begin
        nxt_state = ST_RD_CAP;
        tmr_load  = 1'b1;
      end
      ST_RD_CAP: if (tmr_expired) begin
        nxt_state = ST_RECOVER;
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(REC_CYC - 1);
      end
      ST_WR_SETUP: if (tmr_expired) begin
        nxt_state = ST_WR_PULSE;
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(PW_CYC - 1);
      end
      ST_WR_PULSE: if (tmr_expired) begin
        nxt_state = ST_WR_HOLD;
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(HD_CYC - 1);
      end
      ST_WR_HOLD: if (tmr_expired) begin
        nxt_state = ST_RECOVER;
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(REC_CYC - 1);
      end
      ST_RECOVER: if (tmr_expired) nxt_state = ST_IDLE;
      default: nxt_state = ST_IDLE;
    endcase
  end

  assign want_drive = (nxt_state == ST_WR_SETUP) || (nxt_state == ST_WR_PULSE) ||
                      (nxt_state == ST_WR_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= nxt_state;
      if (accept) addr_q <= req_addr;
      if (state_q == ST_RD_CAP) rdata_q <= mem_dq_in;
      rsp_q <= (state_q == ST_RD_CAP) ||
               ((state_q == ST_WR_HOLD) && tmr_expired);
    end
  end

  sram_phase_timer #(.CW(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_strobe_gen u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_state (nxt_state),
    .ce1_n     (mem_ce1_n),
    .ce2       (mem_ce2),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n)
  );

  sram_bus_turn #(.DATA_W(DATA_W)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .want_drive (want_drive),
    .oe_n_now   (mem_oe_n),
    .load       (accept && req_write),
    .din        (req_wdata),
    .dout       (mem_dq_out),
    .drive_en   (mem_dq_oe)
  );

  assign mem_addr  = addr_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RD_CYC = 14,
  parameter int unsigned PW_CYC = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  logic [15:0] we_cnt, oe_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_cnt <= '0;
      oe_cnt <= '0;
    end else begin
      we_cnt <= mem_we_n ? 16'd0 : we_cnt + 16'd1;
      oe_cnt <= mem_oe_n ? 16'd0 : oe_cnt + 16'd1;
    end
  end

  p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_read_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce1_n && mem_ce2 && mem_we_n));

  p_read_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_cnt >= 16'(RD_CYC + 1)));

  p_we_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_oe_n));

  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_cnt >= 16'(PW_CYC)));

  p_data_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && $stable(mem_dq_out)));

  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce1_n && $stable(mem_dq_out)));

  p_addr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

  p_rsp_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_no_fight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_drive_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  p_turn_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  p_recover_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!req_ready && mem_we_n && mem_ce1_n && !mem_ce2));
endmodule

bind sram_ctl_top sram_ctl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .RD_CYC (RD_CYC),
  .PW_CYC (PW_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce1_n  (mem_ce1_n),
  .mem_ce2    (mem_ce2),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_ctl_top_tb.sv
module sram_ctl_top_tb;
  localparam int CLK_PS = 4000;
  localparam int RD  = (55000 + CLK_PS - 1) / CLK_PS;
  localparam int SU  = 1;
  localparam int PW  = (45000 + CLK_PS - 1) / CLK_PS;
  localparam int HD  = 1;
  localparam int REC = 1;
  localparam int WTOT = SU + PW + HD;

  // {write, addr, wdata, expected rsp_rdata}
  localparam logic [33:0] VECS [0:7] = '{
    {1'b1, 17'h00012, 8'h5A, 8'h00},
    {1'b1, 17'h1FF34, 8'hC3, 8'h00},
    {1'b0, 17'h00012, 8'h00, 8'h5A},
    {1'b1, 17'h00056, 8'hA5, 8'h5A},
    {1'b0, 17'h1FF34, 8'h00, 8'hC3},
    {1'b1, 17'h00012, 8'hFF, 8'hC3},
    {1'b0, 17'h00012, 8'h00, 8'hFF},
    {1'b0, 17'h00056, 8'h00, 8'hA5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int viol_r7 = 0;
  int viol_r9 = 0;

  logic [7:0] ram [0:255];

  always #2 clk = ~clk;

  sram_ctl_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Small RAM model: read when selected with outputs on, write during the pulse.
  assign mem_dq_in = (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) ?
                     ram[mem_addr[7:0]] : 8'hEE;

  logic        p_ok = 1'b0;
  logic        p_ce1_n, p_oe_n, p_dq_oe;
  logic [16:0] p_addr;

  always @(negedge clk) begin
    if (!mem_ce1_n && mem_ce2 && !mem_we_n && mem_dq_oe)
      ram[mem_addr[7:0]] = mem_dq_out;
    if (!rst_n) p_ok = 1'b0;
    else begin
      if (p_ok) begin
        if (!mem_ce1_n && !p_ce1_n && mem_addr != p_addr) viol_r7++;
        if (mem_dq_oe && !mem_oe_n) viol_r9++;
        if (mem_dq_oe && !p_dq_oe && !p_oe_n) viol_r9++;
        if (!mem_oe_n && p_oe_n && p_dq_oe) viol_r9++;
      end
      p_ok = 1'b1;
      p_ce1_n = mem_ce1_n;
      p_oe_n = mem_oe_n;
      p_dq_oe = mem_dq_oe;
      p_addr = mem_addr;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pins();
    return {27'd0, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe};
  endfunction

  task automatic do_access(input logic w, input logic [16:0] a,
                           input logic [7:0] d, input logic [7:0] e);
    int rsp_j, rdy_j;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rsp_j = w ? WTOT : RD + 1;
    rdy_j = rsp_j + REC;
    for (int j = 0; j <= rdy_j; j++) begin
      logic act, we_exp;
      act = w ? (j < WTOT) : (j <= RD);
      we_exp = w ? !(j >= SU && j < SU + PW) : 1'b1;
      chk(w ? "R5 strobes" : "R3 strobes", pins(),
          {27'd0, !act, act, w ? 1'b1 : !act, we_exp, w ? act : 1'b0});
      if (act) chk("R7 addr", 32'(mem_addr), 32'(a));
      if (act && w) chk("R6 data", 32'(mem_dq_out), 32'(d));
      chk("R8 rsp pulse", 32'(rsp_valid), 32'(j == rsp_j));
      chk("R10 ready", 32'(req_ready), 32'(j >= rdy_j));
      if (j == rsp_j) chk(w ? "R11 rdata kept" : "R4 rdata", 32'(rsp_rdata), 32'(e));
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", pins(), 32'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pins idle", pins(), 32'b10110);
    chk("R1 ready idle", 32'(req_ready), 32'd1);
    chk("R1 no rsp", 32'(rsp_valid), 32'd0);
    chk("R11 rdata reset", 32'(rsp_rdata), 32'd0);

    for (int v = 0; v < 8; v++)
      do_access(VECS[v][33], VECS[v][32:16], VECS[v][15:8], VECS[v][7:0]);

    // Write with a read held pending behind it (R2, R9).
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00077; req_wdata = 8'h3C;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_write = 1'b0; req_addr = 17'h00077; req_wdata = 8'h00;
    for (int j = 0; j < WTOT + REC; j++) begin
      chk("R2 busy ready low", 32'(req_ready), 32'd0);
      if (j == WTOT) chk("R9 drive off", {30'd0, mem_dq_oe, mem_oe_n}, 32'b01);
      @(negedge clk);
    end
    chk("R2 ready back", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 pending read taken", {14'd0, mem_addr, mem_oe_n}, {14'd0, 17'h00077, 1'b0});
    for (int k = 1; k <= RD + 1; k++) @(negedge clk);
    chk("R8 read rsp", 32'(rsp_valid), 32'd1);
    chk("R4 read after write", 32'(rsp_rdata), 32'h3C);
    repeat (REC + 1) @(negedge clk);

    // Reset in the middle of the write pulse (R1).
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h000C0; req_wdata = 8'h99;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (SU + 1) @(negedge clk);
    chk("R5 pulse active", 32'(mem_we_n), 32'd0);
    rst_n = 1'b0;
    #1;
    chk("R1 async deselect", pins(), 32'b10110);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_access(1'b0, 17'h1FF34, 8'h00, 8'hC3);

    chk("R7 addr stable while selected", 32'(viol_r7), 32'd0);
    chk("R9 bus turnaround", 32'(viol_r9), 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog act=%h exp=%h", 1'b0, 1'b1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule